// File: doc/BRIEF.md
# Programmable Down-Counting Clock Divider

This block divides an input clock by an 8-bit ratio. A chain of 4-bit down-counting stages holds the current count. The lowest stage decrements on every clock. Each higher stage decrements only when every stage below it borrows. When the whole count reaches its terminal value, the block reloads the ratio from the input. On that same edge it raises its output for one clock. The result is one output pulse for every N input clocks.

The ratio input is sampled only at reset and at each reload. A change between reloads therefore takes effect from the next period. A ratio of zero is not allowed. If it is applied, the block loads 1 in its place and raises an error flag. The flag stays up until a reload picks up a nonzero ratio.

Top module: `clkdiv_dn`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tick_o` and `bad_ratio_o` (for a nonzero ratio) go low and the count loads the ratio. After release, the first `tick_o` is high in the cycle that follows the N-th rising edge.
- R2: For every ratio N from 1 to 255, consecutive rising edges of `tick_o` are exactly N clocks apart. Here N is the unsigned binary value of `ratio_i`, and bit 0 is the least significant bit.
- R3: For N of 2 or more, `tick_o` stays high for exactly one clock per period.
- R4: For N = 1, `tick_o` stays high on every clock.
- R5: A change of `ratio_i` between reloads leaves the running period unchanged. The new value sets the length of the period that starts at the next reload.
- R6: A ratio of 0 sampled at a reload or at reset acts as 1, so `tick_o` fires every clock and `bad_ratio_o` is high. A later reload of a nonzero ratio clears `bad_ratio_o`.
- R7: A higher 4-bit stage holds its value unless every lower stage is at 0 in that clock. Periods that cross a 16-count boundary (16, 17, 255) therefore keep their exact length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; loads the ratio |
| ratio_i | input | 8 | Divide ratio N, unsigned binary |
| tick_o | output | 1 | One-clock pulse per N input clocks |
| bad_ratio_o | output | 1 | High while the ratio in use was sampled as 0 |

## Verification
The bench sweeps every ratio from 1 to 255. For each ratio it measures the delay from reset and then one full period, which catches an off-by-one terminal value (periods of N+1 or N-1). The sweep also catches a faulty borrow between stages, which would distort every ratio above 15. Ratio 1 is checked on its own: a design that drops the pulse between back-to-back reloads would show gaps. A mid-period change of `ratio_i` exposes a design that samples the ratio on every clock, because that design shortens or stretches the running period. Ratio 0 is checked for a hang or an unbounded count, and for the error flag rising and then clearing.

// File: rtl/clkdiv_pkg.sv
// Shared sizing for the divider and the rule that turns a forbidden ratio into a safe one.
// Assumes at least two counting stages.
package clkdiv_pkg;
    parameter int STAGE_W   = 4;
    parameter int NUM_STAGE = 2;
    localparam int RATIO_W  = STAGE_W * NUM_STAGE;

    // A zero ratio is replaced by 1 so the counter never wraps through the full range.
    function automatic logic [RATIO_W-1:0] safe_ratio(input logic [RATIO_W-1:0] r);
        return (r == '0) ? RATIO_W'(1) : r;
    endfunction
endpackage

// File: rtl/clkdiv_stage.sv
// One down-counting slice of the divider.
// It loads its slice of the ratio on reset or reload, and otherwise decrements when borrow_i is high.
// Assumes the caller drives borrow_i high only when all lower slices are zero.
module clkdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         borrow_i,
    output logic [W-1:0] nib_o,
    output logic         zero_o
);
    logic [W-1:0] nib_q;

    // Slice register: load takes priority, then decrement on borrow.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)
            nib_q <= load_val_i;
        else if (borrow_i)
            nib_q <= nib_q - W'(1);
    end

    assign nib_o  = nib_q;
    assign zero_o = (nib_q == '0);

    // A slice with no borrow and no load must keep its value.
    assert_hold_without_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!borrow_i && !load_i) |=> $stable(nib_q))
        else $error("slice moved without a borrow");
endmodule

// File: rtl/clkdiv_tc.sv
// Terminal-count detector: the whole count equals 1 when the low slice is 1 and every upper slice is 0.
// Assumes NUM >= 2 slices.
module clkdiv_tc #(
    parameter int W   = 4,
    parameter int NUM = 2
) (
    input  logic [W-1:0]   low_nib_i,
    input  logic [NUM-2:0] upper_zero_i,
    output logic           tc_o
);
    // Combine the low-slice match with the upper-slice zero flags.
    always_comb begin
        tc_o = (low_nib_i == W'(1)) && (&upper_zero_i);
    end
endmodule

// File: rtl/clkdiv_dn.sv
// Programmable clock divider built from cascaded down-counting slices.
// The count reloads the ratio at terminal count, and tick_o pulses on that edge.
// Assumes ratio_i is stable around the clock edge; a zero ratio is run as 1 and flagged.
module clkdiv_dn
    import clkdiv_pkg::*;
#(
    parameter int SW = clkdiv_pkg::STAGE_W,
    parameter int NS = clkdiv_pkg::NUM_STAGE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SW*NS-1:0] ratio_i,
    output logic           tick_o,
    output logic           bad_ratio_o
);
    localparam int RW = SW * NS;

    logic [RW-1:0] load_val;
    logic [RW-1:0] cnt;
    logic [NS-1:0] zero;
    logic [NS-1:0] borrow;
    logic          tc;
    logic          tick_q;
    logic          bad_q;

    assign load_val = RW'(safe_ratio(RATIO_W'(ratio_i)));
    assign borrow[0] = 1'b1;

    genvar k;
    generate
        for (k = 0; k < NS; k++) begin : g_stage
            if (k > 0) begin : g_chain
                assign borrow[k] = borrow[k-1] & zero[k-1];
            end
            clkdiv_stage #(.W(SW)) u_stage (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (tc),
                .load_val_i (load_val[k*SW +: SW]),
                .borrow_i   (borrow[k]),
                .nib_o      (cnt[k*SW +: SW]),
                .zero_o     (zero[k])
            );
        end
    endgenerate

    clkdiv_tc #(.W(SW), .NUM(NS)) u_tc (
        .low_nib_i    (cnt[SW-1:0]),
        .upper_zero_i (zero[NS-1:1]),
        .tc_o         (tc)
    );

    // Output pulse: registered copy of terminal count, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tc;
    end

    // Error flag: records whether the ratio sampled at reset or reload was zero.
    always_ff @(posedge clk) begin
        if (!rst_n || tc) bad_q <= (ratio_i == '0);
    end

    assign tick_o      = tick_q;
    assign bad_ratio_o = bad_q;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !tick_o)
        else $error("tick not cleared by reset");

    assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cnt == $past(load_val)))
        else $error("reload value wrong");

    assert_single_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cnt != RW'(1)) |=> !tick_o)
        else $error("tick wider than one clock");

    assert_never_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0)
        else $error("count reached zero");

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && ratio_i == '0) |=> (bad_ratio_o && cnt == RW'(1)))
        else $error("zero ratio not replaced or not flagged");
endmodule

// File: tb/clkdiv_dn_tb.sv
module clkdiv_dn_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ratio = 8'd1;
    logic       tick;
    logic       bad;
    int total = 0;
    int badn  = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    clkdiv_dn u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_i    (ratio),
        .tick_o     (tick),
        .bad_ratio_o(bad)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            badn++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until tick is seen high (limit guards a hang).
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 600);
    endtask

    task automatic do_reset(input logic [7:0] r);
        @(negedge clk);
        ratio = r;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n;
        // R1 reset state
        do_reset(8'd9);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 flag in reset", int'(bad), 0);
        rst_n = 1'b1;
        wait_tick(n);
        check("R1 first tick delay N=9", n, 9);

        // R2/R7 sweep of every ratio; R3 width; R4 ratio 1
        for (int r = 1; r < 256; r++) begin
            do_reset(8'(r));
            rst_n = 1'b1;
            wait_tick(n);
            check($sformatf("R1 first delay N=%0d", r), n, r);
            @(negedge clk);
            check($sformatf("%s level after tick N=%0d", (r == 1) ? "R4" : "R3", r),
                  int'(tick), (r == 1) ? 1 : 0);
            if (r == 1) n = 1;
            else begin
                wait_tick(n);
                n = n + 1;
            end
            check($sformatf("%s period N=%0d",
                  (r == 16 || r == 17 || r == 255) ? "R7" : "R2", r), n, r);
        end

        // R4 ratio 1 stays high for several clocks
        do_reset(8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check("R4 tick held high", int'(tick), 1);
            @(negedge clk);
        end

        // R5 ratio change applies only at the next reload
        do_reset(8'd10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        ratio = 8'd20;
        wait_tick(n);
        check("R5 period unchanged by mid change", n + 3, 10);
        repeat (4) @(negedge clk);
        ratio = 8'd5;
        wait_tick(n);
        check("R5 new ratio used from reload", n + 4, 20);
        wait_tick(n);
        check("R5 later change applied", n, 5);

        // R6 zero ratio acts as 1 and sets the flag
        do_reset(8'd0);
        check("R6 flag set at reset", int'(bad), 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check("R6 tick every clock", int'(tick), 1);
            check("R6 flag held", int'(bad), 1);
            @(negedge clk);
        end
        ratio = 8'd7;
        @(negedge clk);
        check("R6 flag cleared after reload", int'(bad), 0);
        wait_tick(n);
        check("R6 period after recovery", n, 7);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, badn);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            badn++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, badn);
            $finish;
        end
    end
endmodule